// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Channel

This block is one full-duplex asynchronous serial line with four bus-visible registers: receive status, receive buffer, transmit status and transmit buffer. A bus master selects a register with a two-bit select, reads it through a combinational read-data port and writes it with a write strobe. The line format is set by four configuration inputs: 7 or 8 data bits, parity on or off, odd or even parity, and one or two stop bits. All serial timing comes from an external oversampling tick that runs at 16 times the bit rate. Address decoding and the bit-rate generator belong to the surrounding chip.

The receiver finds the start edge, samples each bit at its middle and places the character in the receive buffer. With the character it records parity, framing and overrun status. The transmitter has a one-character holding buffer in front of a shift register. It starts a character only while clear-to-send is high. It can force the line to a steady space level for a break. Each direction raises an interrupt request when its ready flag and its enable are both set. A bus init input returns the register state to its idle values.

Top module: `sio_channel`

## Requirements
- R1: Receive status bit 7 (done) sets once a complete character has been received. It clears on a read of the receive buffer (select 1 with read strobe) and on bus init. Writes do not change it.
- R2: Receive status bit 6 (receive interrupt enable) is read/write. `rx_irq` is high exactly while done and this enable are both set.
- R3: In the receive buffer, bit 12 is the parity error, bit 13 the framing error and bit 14 the overrun. Bit 15 is the OR of bits 14 to 12. The parity error is always 0 while parity is disabled.
- R4: Overrun is recorded only when a character completes while done is still set. All error bits are replaced with the status of each newly completed character.
- R5: Received data is right-justified in bits 7:0. Bit 7 reads 0 in 7-bit mode. Bits 11:8 of the receive buffer read 0, and so do all unused bits of both status registers.
- R6: A transmitted character is a start bit (0), the data bits LSB first, an optional parity bit (odd or even) and one or two stop bits (1). Each bit lasts 16 ticks.
- R7: Transmit status bit 7 (ready) is 0 while the transmit buffer holds a character and 1 once the shifter has taken it. A write to the transmit buffer (select 3) fills the buffer.
- R8: While `cts` is low, no new character starts. A character that has already started is sent to its end.
- R9: While transmit status bit 0 (break) is set, `txd` is held at 0. Ready and the transmit interrupt keep working during break.
- R10: Transmit status bit 6 (transmit interrupt enable) is read/write. `tx_irq` is high exactly while ready and this enable are both set.
- R11: A character whose first stop bit is sampled as 0 sets the framing error.
- R12: Bus init clears done, both interrupt enables, break and the error bits, and sets transmit ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| bus_init | input | 1 | Synchronous bus init, returns registers to idle |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_eight | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| reg_sel | input | 2 | 0 receive status, 1 receive buffer, 2 transmit status, 3 transmit buffer |
| rd_en | input | 1 | Read strobe, side effect on the receive buffer only |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Clear to send, high allows a character to start |
| txd | output | 1 | Serial transmit line |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The hardest state to reach is an overrun. Reaching it needs a second complete, well-framed character to land while the first is still unread. The bench sends two frames back to back without touching the receive buffer, then reads it. It then sends a third, clean character after the read to show that all error bits are replaced. A second hard case is a CTS drop in the middle of a character. The bench lowers `cts` just after it sees the start edge, then checks that every remaining bit still arrives in place.

// File: rtl/sio_pkg.sv
package sio_pkg;

   typedef struct packed {
      logic eight;
      logic par_en;
      logic par_even;
      logic two_stop;
   } sio_cfg_t;

   typedef enum logic [1:0] {
      SEL_RSTAT = 2'd0,
      SEL_RBUF  = 2'd1,
      SEL_TSTAT = 2'd2,
      SEL_TBUF  = 2'd3
   } sio_sel_e;

   localparam int FRAME_MAX = 12;

   // parity bit that makes the total count of ones even or odd
   function automatic logic par_bit(input logic [7:0] d, input logic even);
      return (^d) ^ ~even;
   endfunction

   function automatic logic [7:0] data_mask(input logic [7:0] d, input logic eight);
      return {d[7] & eight, d[6:0]};
   endfunction

   // start + data + parity + stop bits
   function automatic logic [3:0] frame_len(input sio_cfg_t c);
      return 4'd2 + (c.eight ? 4'd8 : 4'd7) + {3'd0, c.par_en} + {3'd0, c.two_stop};
   endfunction

   // frame bits LSB first, padded with mark level
   function automatic logic [FRAME_MAX-1:0] build_frame(input logic [7:0] d, input sio_cfg_t c);
      logic [FRAME_MAX-1:0] f;
      logic                 p;
      f      = '1;
      p      = par_bit(data_mask(d, c.eight), c.par_even);
      f[0]   = 1'b0;
      f[7:1] = d[6:0];
      if (c.eight) begin
         f[8] = d[7];
         if (c.par_en) f[9] = p;
      end else if (c.par_en) begin
         f[8] = p;
      end
      return f;
   endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {STAGES{RST_VAL}};
            else        q <= {q[STAGES-2+1-1:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
#(
   parameter int OVS = 16,
   localparam int CW = $clog2(OVS)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       tick,
   input  logic       rxd_s,
   input  sio_cfg_t   cfg,
   output logic       fin,
   output logic [7:0] fin_data,
   output logic       fin_frm,
   output logic       fin_par
);
   typedef enum logic [2:0] {RX_IDLE, RX_START, RX_BITS, RX_FIN, RX_WAIT} rx_st_e;

   rx_st_e        st;
   logic [CW-1:0] cnt;
   logic [3:0]    idx;
   logic [9:0]    sh;
   logic [3:0]    nsamp;
   logic [3:0]    nb;
   logic          par_rx;
   logic          stop_rx;

   assign nb    = cfg.eight ? 4'd8 : 4'd7;
   assign nsamp = nb + {3'd0, cfg.par_en} + 4'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= RX_IDLE;
         cnt <= '0;
         idx <= '0;
         sh  <= '0;
      end else if (clr) begin
         st  <= RX_IDLE;
         cnt <= '0;
         idx <= '0;
      end else begin
         case (st)
            RX_IDLE: if (tick && !rxd_s) begin
               st  <= RX_START;
               cnt <= '0;
            end
            RX_START: if (tick) begin
               if (cnt == CW'(OVS/2 - 1)) begin
                  cnt <= '0;
                  idx <= '0;
                  st  <= rxd_s ? RX_IDLE : RX_BITS;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_BITS: if (tick) begin
               if (cnt == CW'(OVS - 1)) begin
                  cnt     <= '0;
                  sh[idx] <= rxd_s;
                  idx     <= idx + 1'b1;
                  if (idx == nsamp - 4'd1) st <= RX_FIN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_FIN:  st <= stop_rx ? RX_IDLE : RX_WAIT;
            RX_WAIT: if (rxd_s) st <= RX_IDLE;
            default: st <= RX_IDLE;
         endcase
      end
   end

   assign par_rx   = sh[nb];
   assign stop_rx  = sh[nb + {3'd0, cfg.par_en}];
   assign fin      = (st == RX_FIN);
   assign fin_data = data_mask(sh[7:0], cfg.eight);
   assign fin_frm  = ~stop_rx;
   assign fin_par  = cfg.par_en & (par_rx != par_bit(fin_data, cfg.par_even));
endmodule

// File: rtl/sio_tx.sv
module sio_tx
   import sio_pkg::*;
#(
   parameter int OVS = 16,
   localparam int CW = $clog2(OVS)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       tick,
   input  sio_cfg_t   cfg,
   input  logic       req,
   input  logic       cts,
   input  logic [7:0] data,
   output logic       take,
   output logic       busy,
   output logic       line
);
   logic [FRAME_MAX-1:0] sh;
   logic [CW-1:0]        cnt;
   logic [3:0]           rem;

   assign take = !busy && req && cts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sh   <= '1;
         cnt  <= '0;
         rem  <= '0;
      end else if (clr) begin
         busy <= 1'b0;
         sh   <= '1;
         cnt  <= '0;
      end else if (!busy) begin
         if (take) begin
            busy <= 1'b1;
            sh   <= build_frame(data, cfg);
            rem  <= frame_len(cfg) - 4'd1;
            cnt  <= '0;
         end
      end else if (tick) begin
         if (cnt == CW'(OVS - 1)) begin
            cnt <= '0;
            sh  <= {1'b1, sh[FRAME_MAX-1:1]};
            if (rem == '0) busy <= 1'b0;
            else           rem  <= rem - 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign line = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/sio_channel.sv
module sio_channel
   import sio_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int REG_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_init,
   input  logic             tick,
   input  logic             cfg_eight,
   input  logic             cfg_par_en,
   input  logic             cfg_par_even,
   input  logic             cfg_two_stop,
   input  logic [1:0]       reg_sel,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic             rxd,
   input  logic             cts,
   output logic             txd,
   output logic             rx_irq,
   output logic             tx_irq
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (REG_W != 16) begin : g_bad_w
         $error("REG_W must be 16");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   sio_cfg_t   cfg;
   sio_sel_e   sel;
   logic       rxd_s;
   logic       rx_fin;
   logic [7:0] fin_data;
   logic       fin_frm, fin_par;

   logic       rx_done_q, rx_ie_q, ovr_q, frm_q, par_q;
   logic [7:0] rx_data_q;
   logic       tx_full_q, tx_ie_q, brk_q;
   logic [7:0] tx_data_q;
   logic       tx_take, tx_busy, tx_line;

   assign cfg = '{eight: cfg_eight, par_en: cfg_par_en, par_even: cfg_par_even, two_stop: cfg_two_stop};
   assign sel = sio_sel_e'(reg_sel);

   sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
   );

   sio_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(bus_init), .tick(tick), .rxd_s(rxd_s), .cfg(cfg),
      .fin(rx_fin), .fin_data(fin_data), .fin_frm(fin_frm), .fin_par(fin_par)
   );

   sio_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(bus_init), .tick(tick), .cfg(cfg),
      .req(tx_full_q), .cts(cts), .data(tx_data_q),
      .take(tx_take), .busy(tx_busy), .line(tx_line)
   );

   // receive side registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_done_q <= 1'b0;
         rx_ie_q   <= 1'b0;
         ovr_q     <= 1'b0;
         frm_q     <= 1'b0;
         par_q     <= 1'b0;
         rx_data_q <= '0;
      end else if (bus_init) begin
         rx_done_q <= 1'b0;
         rx_ie_q   <= 1'b0;
         ovr_q     <= 1'b0;
         frm_q     <= 1'b0;
         par_q     <= 1'b0;
      end else begin
         if (wr_en && sel == SEL_RSTAT) rx_ie_q <= wdata[6];
         if (rd_en && sel == SEL_RBUF)  rx_done_q <= 1'b0;
         if (rx_fin) begin
            rx_done_q <= 1'b1;
            ovr_q     <= rx_done_q;
            frm_q     <= fin_frm;
            par_q     <= fin_par;
            rx_data_q <= fin_data;
         end
      end
   end

   // transmit side registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_full_q <= 1'b0;
         tx_ie_q   <= 1'b0;
         brk_q     <= 1'b0;
         tx_data_q <= '0;
      end else if (bus_init) begin
         tx_full_q <= 1'b0;
         tx_ie_q   <= 1'b0;
         brk_q     <= 1'b0;
      end else begin
         if (tx_take) tx_full_q <= 1'b0;
         if (wr_en && sel == SEL_TBUF) begin
            tx_full_q <= 1'b1;
            tx_data_q <= data_mask(wdata[7:0], cfg.eight);
         end
         if (wr_en && sel == SEL_TSTAT) begin
            tx_ie_q <= wdata[6];
            brk_q   <= wdata[0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_RSTAT: begin
            rdata[7] = rx_done_q;
            rdata[6] = rx_ie_q;
         end
         SEL_RBUF: begin
            rdata[15]  = ovr_q | frm_q | par_q;
            rdata[14]  = ovr_q;
            rdata[13]  = frm_q;
            rdata[12]  = par_q;
            rdata[7:0] = data_mask(rx_data_q, cfg.eight);
         end
         SEL_TSTAT: begin
            rdata[7] = ~tx_full_q;
            rdata[6] = tx_ie_q;
            rdata[0] = brk_q;
         end
         default: rdata = '0;
      endcase
   end

   assign txd    = tx_line & ~brk_q;
   assign rx_irq = rx_done_q & rx_ie_q;
   assign tx_irq = ~tx_full_q & tx_ie_q;
endmodule

// File: rtl/sio_channel_chk.sv
module sio_channel_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_init,
   input logic        cfg_par_en,
   input logic        cfg_eight,
   input logic        cts,
   input logic [1:0]  reg_sel,
   input logic [15:0] rdata,
   input logic        txd,
   input logic        rx_fin,
   input logic        rx_done_q,
   input logic        rx_ie_q,
   input logic        tx_ie_q,
   input logic        brk_q,
   input logic        tx_full_q,
   input logic        ovr_q,
   input logic        par_q,
   input logic        tx_busy
);
   assert_done_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fin && !bus_init) |=> rx_done_q);

   assert_overrun_when_unread_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fin && !bus_init && rx_done_q) |=> ovr_q);

   assert_no_overrun_when_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fin && !rx_done_q) |=> !ovr_q);

   assert_no_par_err_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fin && !cfg_par_en) |=> !par_q);

   assert_seven_bit_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd1 && !cfg_eight) |-> (rdata[7] == 1'b0 && rdata[11:8] == 4'd0));

   assert_start_needs_cts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(cts));

   assert_break_holds_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
      brk_q |-> !txd);

   assert_init_idles_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_init |=> (!rx_done_q && !rx_ie_q && !tx_ie_q && !brk_q && !tx_full_q));
endmodule

bind sio_channel sio_channel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .cfg_par_en(cfg_par_en),
   .cfg_eight(cfg_eight), .cts(cts), .reg_sel(reg_sel), .rdata(rdata), .txd(txd),
   .rx_fin(rx_fin), .rx_done_q(rx_done_q), .rx_ie_q(rx_ie_q), .tx_ie_q(tx_ie_q),
   .brk_q(brk_q), .tx_full_q(tx_full_q), .ovr_q(ovr_q), .par_q(par_q), .tx_busy(tx_busy)
);

// File: tb/sio_channel_test.sv
module sio_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_init = 1'b0;
   logic        tick = 1'b1;
   logic        cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        rxd = 1'b1, cts = 1'b1;
   logic        txd, rx_irq, tx_irq;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   sio_channel uut (
      .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .tick(tick),
      .cfg_eight(cfg_eight), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .cfg_two_stop(cfg_two_stop), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .rxd(rxd), .cts(cts), .txd(txd),
      .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input bit e, input bit p, input bit ev, input bit two);
      cfg_eight = e; cfg_par_en = p; cfg_par_even = ev; cfg_two_stop = two;
   endtask

   task automatic peek(input logic [1:0] s, output logic [15:0] v);
      @(negedge clk);
      reg_sel = s;
      #1 v = rdata;
   endtask

   task automatic rd(input logic [1:0] s, output logic [15:0] v);
      @(negedge clk);
      reg_sel = s; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] v);
      @(negedge clk);
      reg_sel = s; wdata = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drive_bit(input logic b);
      @(negedge clk);
      rxd = b;
      repeat (15) @(negedge clk);
   endtask

   // serial frame on rxd using the current configuration
   task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
      int  nb;
      logic p;
      nb = cfg_eight ? 8 : 7;
      p  = 1'b0;
      for (int i = 0; i < nb; i++) p = p ^ d[i];
      if (!cfg_par_even) p = ~p;
      drive_bit(1'b0);
      for (int i = 0; i < nb; i++) drive_bit(d[i]);
      if (cfg_par_en) drive_bit(p ^ bad_par);
      drive_bit(!bad_stop);
      drive_bit(1'b1);
      if (cfg_two_stop) drive_bit(1'b1);
      @(negedge clk);
      rxd = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // expected transmit frame, LSB first
   task automatic exp_frame(input logic [7:0] d, output logic [11:0] f, output int len);
      int  nb;
      logic p;
      nb = cfg_eight ? 8 : 7;
      p  = 1'b0;
      for (int i = 0; i < nb; i++) p = p ^ d[i];
      if (!cfg_par_even) p = ~p;
      f = '1; f[0] = 1'b0;
      for (int i = 0; i < nb; i++) f[1+i] = d[i];
      len = 1 + nb;
      if (cfg_par_en) begin f[len] = p; len++; end
      len = len + (cfg_two_stop ? 2 : 1);
   endtask

   task automatic watch_tx(input string req, input logic [7:0] d, input bit drop_cts);
      logic [11:0] f;
      logic [11:0] got;
      int          len;
      int          waited;
      exp_frame(d, f, len);
      got = '1;
      waited = 0;
      while (txd !== 1'b0 && waited < 200) begin
         @(negedge clk);
         waited++;
      end
      if (drop_cts) cts = 1'b0;
      repeat (7) @(negedge clk);
      for (int i = 0; i < len; i++) begin
         got[i] = txd;
         if (i != len - 1) repeat (16) @(negedge clk);
      end
      check(req, {4'd0, got}, {4'd0, f});
      repeat (12) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      peek(2'd0, v); check("R1 reset rx status", v, 16'h0000);
      peek(2'd2, v); check("R7 reset tx status", v, 16'h0080);
      check("R9 reset txd idle", {15'd0, txd}, 16'h0001);
      check("R2 reset irqs", {14'd0, rx_irq, tx_irq}, 16'h0000);
   endtask

   task automatic t_rx_basic();
      logic [15:0] v;
      set_cfg(1, 0, 0, 0);
      send_rx(8'hA5, 0, 0);
      peek(2'd0, v); check("R1 done after char", v, 16'h0080);
      wr(2'd0, 16'h0000);
      peek(2'd0, v); check("R1 write leaves done", v, 16'h0080);
      rd(2'd1, v);  check("R5 8N1 data A5", v, 16'h00A5);
      peek(2'd0, v); check("R1 done cleared by read", v, 16'h0000);
   endtask

   task automatic t_rx_seven();
      logic [15:0] v;
      set_cfg(0, 1, 1, 0);
      send_rx(8'h55, 0, 0);
      rd(2'd1, v); check("R5 7E1 data, bit7 zero", v, 16'h0055);
      send_rx(8'hFF, 0, 0);
      rd(2'd1, v); check("R5 7E1 upper bit dropped", v, 16'h007F);
   endtask

   task automatic t_rx_parity();
      logic [15:0] v;
      set_cfg(1, 1, 0, 0);
      send_rx(8'h3C, 1, 0);
      rd(2'd1, v); check("R3 odd parity error", v, 16'h903C);
      set_cfg(1, 1, 1, 1);
      send_rx(8'h81, 0, 0);
      rd(2'd1, v); check("R4 errors replaced, 8E2 good", v, 16'h0081);
   endtask

   task automatic t_rx_framing();
      logic [15:0] v;
      set_cfg(1, 0, 0, 0);
      send_rx(8'h12, 0, 1);
      rd(2'd1, v); check("R11 framing error", v, 16'hA012);
      send_rx(8'h34, 0, 0);
      rd(2'd1, v); check("R3 parity off no error", v, 16'h0034);
   endtask

   task automatic t_overrun();
      logic [15:0] v;
      set_cfg(1, 0, 0, 0);
      send_rx(8'h11, 0, 0);
      send_rx(8'h22, 0, 0);
      rd(2'd1, v); check("R4 overrun on unread", v, 16'hC022);
      send_rx(8'h33, 0, 0);
      rd(2'd1, v); check("R4 overrun replaced", v, 16'h0033);
   endtask

   task automatic t_rx_irq();
      logic [15:0] v;
      wr(2'd0, 16'h0040);
      peek(2'd0, v); check("R2 enable readback", v, 16'h0040);
      check("R2 no irq before char", {15'd0, rx_irq}, 16'h0000);
      send_rx(8'h5A, 0, 0);
      check("R2 irq with done", {15'd0, rx_irq}, 16'h0001);
      rd(2'd1, v);
      check("R2 irq drops after read", {15'd0, rx_irq}, 16'h0000);
      wr(2'd0, 16'h0000);
   endtask

   task automatic t_tx();
      logic [15:0] v;
      set_cfg(1, 0, 0, 0);
      wr(2'd3, 16'h003C);
      #1 check("R7 ready low after write", {15'd0, rdata[7] & (reg_sel == 2'd3 ? 1'b0 : 1'b1)}, 16'h0000);
      watch_tx("R6 8N1 frame 3C", 8'h3C, 0);
      peek(2'd2, v); check("R7 ready after send", v, 16'h0080);
      set_cfg(0, 1, 1, 1);
      wr(2'd3, 16'h004B);
      watch_tx("R6 7E2 frame 4B", 8'h4B, 0);
      set_cfg(1, 1, 0, 0);
      wr(2'd3, 16'h00F0);
      watch_tx("R6 8O1 frame F0", 8'hF0, 0);
   endtask

   task automatic t_cts();
      logic [15:0] v;
      logic        stayed;
      set_cfg(1, 0, 0, 0);
      cts = 1'b0;
      wr(2'd3, 16'h00C3);
      stayed = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) stayed = 1'b0;
      end
      check("R8 no start while cts low", {15'd0, stayed}, 16'h0001);
      peek(2'd2, v); check("R7 buffer held while cts low", v, 16'h0000);
      cts = 1'b1;
      watch_tx("R8 starts after cts", 8'hC3, 0);
      wr(2'd3, 16'h0096);
      watch_tx("R8 finishes after cts drop", 8'h96, 1);
      cts = 1'b1;
   endtask

   task automatic t_break();
      logic [15:0] v;
      logic        low;
      wr(2'd2, 16'h0041);
      peek(2'd2, v); check("R10 break and enable readback", v, 16'h00C1);
      check("R10 tx irq while ready", {15'd0, tx_irq}, 16'h0001);
      wr(2'd3, 16'h0077);
      low = 1'b1;
      for (int i = 0; i < 220; i++) begin
         @(negedge clk);
         if (txd !== 1'b0) low = 1'b0;
      end
      check("R9 line held low in break", {15'd0, low}, 16'h0001);
      check("R9 tx irq returns in break", {15'd0, tx_irq}, 16'h0001);
      wr(2'd2, 16'h0000);
      @(negedge clk);
      check("R9 line idle after break", {15'd0, txd}, 16'h0001);
      check("R10 irq off with enable off", {15'd0, tx_irq}, 16'h0000);
   endtask

   task automatic t_init();
      logic [15:0] v;
      set_cfg(1, 0, 0, 0);
      wr(2'd0, 16'h0040);
      wr(2'd2, 16'h0041);
      send_rx(8'h01, 0, 1);
      @(negedge clk); bus_init = 1'b1;
      @(negedge clk); bus_init = 1'b0;
      peek(2'd0, v); check("R12 rx status cleared", v, 16'h0000);
      peek(2'd2, v); check("R12 tx status idle", v, 16'h0080);
      peek(2'd1, v); check("R12 errors cleared", v & 16'hF000, 16'h0000);
   endtask

   initial begin
      #(20 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_rx_basic();
      t_rx_seven();
      t_rx_parity();
      t_rx_framing();
      t_overrun();
      t_rx_irq();
      t_tx();
      t_cts();
      t_break();
      t_init();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule